// File: doc/BRIEF.md
# Reference clock monitor and timestamp clock selector

This block watches the clocks that feed a timestamp counter, using a 100 MHz reference clock as a ruler. It runs two measurement pairs. One pair counts the external clock over a fixed gate and reports the reference-cycle length of that gate. The other pair does the same for the timestamp clock, which is whichever source the clock-selection circuit currently passes through. Software reads these four numbers and divides them to get each frequency. A gate of 2^27 reference cycles gives a count near 0x00CCCCCC for a 10 MHz clock.

The block also watches the external and internal 10 MHz oscillators for activity, and it holds the switch register that asks for the external source. Two strobe bits set and clear that switch. A 32-bit status word combines the lock and active-source indications from the clock multiplexer with the two missing-clock flags and the switch state. Each target clock runs a free counter in its own domain. The counter value crosses into the reference domain in Gray code. The multiplexer and PLL are outside this block. The block sees only their lock and active-source inputs and the muxed timestamp clock.

Top module: `refclk_monitor`

## Requirements
- R1: Every GATE_CYCLES reference cycles, both reference counts load GATE_CYCLES. Each target count loads the number of rising edges its clock made during that gate, within one edge.
- R2: The status word has this layout: bit 31 lock, bit 30 active source (1 = external), bit 29 external clock missing, bit 28 internal clock missing, bit 27 external-select switch. Bits 26 to 0 read as zero.
- R3: On the cycle after `ctl_pulse[3]` is high, `ext_select` is 0 (clear wins when both bits are high). On the cycle after only `ctl_pulse[4]` is high, `ext_select` is 1. With neither bit high, it holds its value. Status bit 27 shows `ext_select` one cycle later.
- R4: Status bits 31 and 30 show `pll_locked` and `pll_active_ext` as they were sampled one reference cycle earlier.
- R5: Status bit 29 sets once the external clock's transferred count has not changed for more than BAD_LIMIT reference cycles. It clears within a few cycles of the external clock toggling again.
- R6: Status bit 28 behaves the same way for the internal oscillator.
- R7: With the external clock stopped, its target count reads zero for every whole gate.
- R8: While reset is asserted, `ext_select`, the status word and all four counts are zero.
- R9: In steady state, the status reads 0x80000000 for the internal source, 0xC0000000 for the external source, 0x60000000 when the external source is selected but missing and the lock is lost, and 0xA0000000 when the internal source runs and the external clock is missing. Each of these values assumes the switch is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 100 MHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_ext | input | 1 | External clock under measurement |
| clk_ts | input | 1 | Timestamp clock (mux output) under measurement |
| clk_int | input | 1 | Internal oscillator, activity watched |
| ctl_pulse | input | 2 | Strobe bits [4:3]: bit 3 clears, bit 4 sets the switch |
| pll_locked | input | 1 | Lock indication from the clock mux |
| pll_active_ext | input | 1 | Active source from the mux, 1 = external |
| ext_select | output | 1 | External-source request switch |
| ext_ref_count | output | CNT_W | Reference cycles in the last external-clock gate |
| ext_tgt_count | output | CNT_W | External clock edges in the last gate |
| ts_ref_count | output | CNT_W | Reference cycles in the last timestamp-clock gate |
| ts_tgt_count | output | CNT_W | Timestamp clock edges in the last gate |
| status_word | output | 32 | Packed status |

## Verification
The bench builds the block with GATE_CYCLES = 200 and BAD_LIMIT = 64. A gate then lasts 2 µs, so a 25 MHz external clock reads 50 and a 10 MHz clock reads 20 within a few hundred cycles. Stopping a clock for 300 cycles is enough to raise its missing flag well past the threshold. The bench runs all four normal status values, the set/clear priority of the switch, and the recovery of the missing flags. It also checks that a stopped clock reads zero counts.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    localparam int ST_LOCK   = 31;
    localparam int ST_ACTIVE = 30;
    localparam int ST_EXTBAD = 29;
    localparam int ST_INTBAD = 28;
    localparam int ST_SWITCH = 27;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/gray_cdc.sv
module gray_cdc #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_tgt,
    input  logic             clk_ref,
    input  logic             rst_n,
    output logic [CNT_W-1:0] gray_sync
);
    import refmon_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] bin;
        logic [CNT_W-1:0] gray;
    } tgt_t;

    tgt_t tgt_d, tgt_q;
    logic [SYNC_STAGES-1:0][CNT_W-1:0] sync_d, sync_q;

    // target domain: free-running counter and its registered Gray image
    always_comb begin
        tgt_d      = tgt_q;
        tgt_d.bin  = tgt_q.bin + 1'b1;
        tgt_d.gray = CNT_W'(bin_to_gray(32'(tgt_q.bin)));
    end

    always_ff @(posedge clk_tgt or negedge rst_n) begin
        if (!rst_n) tgt_q <= '0;
        else        tgt_q <= tgt_d;
    end

    // reference domain: synchronizer chain
    always_comb begin
        sync_d[0] = tgt_q.gray;
        for (int k = 1; k < SYNC_STAGES; k++) begin
            sync_d[k] = sync_q[k-1];
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign gray_sync = sync_q[SYNC_STAGES-1];

    // R1: a target clock slower than half the reference moves the transferred code by at most one bit per cycle
    a_r1_gray_single_step: assert property (@(posedge clk_ref) disable iff (!rst_n)
        1'b1 |=> $countones(gray_sync ^ $past(gray_sync)) <= 1);

endmodule

// File: rtl/activity_watch.sv
module activity_watch #(
    parameter int CNT_W     = 32,
    parameter int BAD_LIMIT = 64
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gray_in,
    output logic             clk_bad
);
    localparam int ST_W = $clog2(BAD_LIMIT + 2);

    typedef struct packed {
        logic [CNT_W-1:0] prev;
        logic [ST_W-1:0]  stale;
        logic             bad;
    } watch_t;

    watch_t w_d, w_q;
    logic   moved;

    always_comb begin
        w_d      = w_q;
        moved    = (gray_in != w_q.prev);
        w_d.prev = gray_in;
        if (moved) begin
            w_d.stale = '0;
        end else if (w_q.stale <= ST_W'(BAD_LIMIT)) begin
            w_d.stale = w_q.stale + 1'b1;
        end
        w_d.bad = (w_d.stale > ST_W'(BAD_LIMIT));
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign clk_bad = w_q.bad;

    // R5: any movement of the transferred count ends a missing-clock indication on the next cycle
    a_r5_activity_clears: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (gray_in != $past(gray_in)) |=> !clk_bad);

    // R5: the flag cannot appear while the count is still moving
    a_r5_rise_needs_stall: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(clk_bad) |-> $past(gray_in) == $past(gray_in, 2));

endmodule

// File: rtl/gate_latch.sv
module gate_latch #(
    parameter int CNT_W       = 32,
    parameter int GATE_CYCLES = 134217728
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             gate_end,
    input  logic [CNT_W-1:0] gray_in,
    output logic [CNT_W-1:0] ref_count,
    output logic [CNT_W-1:0] tgt_count
);
    import refmon_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] snap;
        logic [CNT_W-1:0] ref_cnt;
        logic [CNT_W-1:0] tgt_cnt;
    } lat_t;

    lat_t l_d, l_q;
    logic [CNT_W-1:0] tgt_bin;

    always_comb begin
        l_d     = l_q;
        tgt_bin = CNT_W'(gray_to_bin(32'(gray_in)));
        if (gate_end) begin
            l_d.tgt_cnt = tgt_bin - l_q.snap;
            l_d.snap    = tgt_bin;
            l_d.ref_cnt = CNT_W'(GATE_CYCLES);
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign ref_count = l_q.ref_cnt;
    assign tgt_count = l_q.tgt_cnt;

    // R1: after a gate closes, the reference count reports the gate length
    a_r1_ref_len: assert property (@(posedge clk_ref) disable iff (!rst_n)
        gate_end |=> ref_count == CNT_W'(GATE_CYCLES));

    // R7: a target count that did not move across a whole gate reports zero
    a_r7_still_zero: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (gate_end && gray_in == l_q.snap && l_q.ref_cnt != '0) |=> tgt_count == '0);

endmodule

// File: rtl/refclk_monitor.sv
module refclk_monitor #(
    parameter int CNT_W       = 32,
    parameter int GATE_CYCLES = 134217728,
    parameter int BAD_LIMIT   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             clk_ext,
    input  logic             clk_ts,
    input  logic             clk_int,
    input  logic [4:3]       ctl_pulse,
    input  logic             pll_locked,
    input  logic             pll_active_ext,
    output logic             ext_select,
    output logic [CNT_W-1:0] ext_ref_count,
    output logic [CNT_W-1:0] ext_tgt_count,
    output logic [CNT_W-1:0] ts_ref_count,
    output logic [CNT_W-1:0] ts_tgt_count,
    output logic [31:0]      status_word
);
    import refmon_pkg::*;

    localparam int GATE_W  = $clog2(GATE_CYCLES + 1);
    localparam int N_TRACK = 3;   // 0 external, 1 timestamp, 2 internal
    localparam int N_MEAS  = 2;   // measured pairs: external, timestamp

    logic [N_TRACK-1:0]            tgt_clk;
    logic [N_TRACK-1:0][CNT_W-1:0] gray_s;
    logic [N_MEAS-1:0][CNT_W-1:0]  ref_cnt, tgt_cnt;
    logic                          ext_bad, int_bad, gate_end;

    assign tgt_clk = {clk_int, clk_ts, clk_ext};

    for (genvar t = 0; t < N_TRACK; t++) begin : g_track
        gray_cdc #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cdc (
            .clk_tgt  (tgt_clk[t]),
            .clk_ref  (clk_ref),
            .rst_n    (rst_n),
            .gray_sync(gray_s[t])
        );
    end

    for (genvar m = 0; m < N_MEAS; m++) begin : g_meas
        gate_latch #(.CNT_W(CNT_W), .GATE_CYCLES(GATE_CYCLES)) u_lat (
            .clk_ref  (clk_ref),
            .rst_n    (rst_n),
            .gate_end (gate_end),
            .gray_in  (gray_s[m]),
            .ref_count(ref_cnt[m]),
            .tgt_count(tgt_cnt[m])
        );
    end

    activity_watch #(.CNT_W(CNT_W), .BAD_LIMIT(BAD_LIMIT)) u_watch_ext (
        .clk_ref(clk_ref), .rst_n(rst_n), .gray_in(gray_s[0]), .clk_bad(ext_bad)
    );

    activity_watch #(.CNT_W(CNT_W), .BAD_LIMIT(BAD_LIMIT)) u_watch_int (
        .clk_ref(clk_ref), .rst_n(rst_n), .gray_in(gray_s[2]), .clk_bad(int_bad)
    );

    typedef struct packed {
        logic [GATE_W-1:0] gate_cnt;
        logic              sel;
        logic [31:0]       status;
    } top_t;

    top_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        gate_end = (s_q.gate_cnt == GATE_W'(GATE_CYCLES - 1));
        s_d.gate_cnt = gate_end ? '0 : s_q.gate_cnt + 1'b1;
        if (ctl_pulse[3]) begin
            s_d.sel = 1'b0;
        end else if (ctl_pulse[4]) begin
            s_d.sel = 1'b1;
        end
        s_d.status            = '0;
        s_d.status[ST_LOCK]   = pll_locked;
        s_d.status[ST_ACTIVE] = pll_active_ext;
        s_d.status[ST_EXTBAD] = ext_bad;
        s_d.status[ST_INTBAD] = int_bad;
        s_d.status[ST_SWITCH] = s_q.sel;
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ext_select    = s_q.sel;
    assign status_word   = s_q.status;
    assign ext_ref_count = ref_cnt[0];
    assign ext_tgt_count = tgt_cnt[0];
    assign ts_ref_count  = ref_cnt[1];
    assign ts_tgt_count  = tgt_cnt[1];

    // R3: clear strobe wins over set
    a_r3_clear_wins: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ctl_pulse[3] |=> !ext_select);

    // R3: set strobe alone sets the switch
    a_r3_set_alone: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (ctl_pulse[4] && !ctl_pulse[3]) |=> ext_select);

    // R3: no strobe, no change
    a_r3_hold: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!ctl_pulse[4] && !ctl_pulse[3]) |=> $stable(ext_select));

    // R3: status mirrors the switch one cycle later
    a_r3_mirror: assert property (@(posedge clk_ref) disable iff (!rst_n)
        1'b1 |=> status_word[ST_SWITCH] == $past(ext_select));

    // R4: lock and active-source bits follow their inputs with one cycle of latency
    a_r4_lock_follow: assert property (@(posedge clk_ref) disable iff (!rst_n)
        1'b1 |=> (status_word[ST_LOCK] == $past(pll_locked)) &&
                 (status_word[ST_ACTIVE] == $past(pll_active_ext)));

endmodule

// File: tb/sim_refclk_monitor.sv
module sim_refclk_monitor;
    localparam int REF_PERIOD = 10;
    localparam int CNT_W      = 32;
    localparam int GATE       = 200;
    localparam int LIMIT      = 64;

    logic clk_ref = 1'b0, clk_ext = 1'b0, clk_int = 1'b0;
    logic rst_n = 1'b0;
    logic ext_on = 1'b0, int_on = 1'b1;
    logic [4:3] ctl_pulse = 2'b00;
    logic pll_locked = 1'b1, pll_active_ext = 1'b0;
    logic clk_ts;
    logic ext_select;
    logic [CNT_W-1:0] ext_ref_count, ext_tgt_count, ts_ref_count, ts_tgt_count;
    logic [31:0] status_word;

    int n_chk = 0, n_fail = 0;
    logic exp_sel = 1'b0;
    logic [2:0] exp_hi = 3'b000;   // lock, active, switch mirror

    always #(REF_PERIOD/2) clk_ref = ~clk_ref;
    always #20 if (ext_on) clk_ext = ~clk_ext;     // 25 MHz
    always #50 if (int_on) clk_int = ~clk_int;     // 10 MHz
    assign clk_ts = pll_active_ext ? clk_ext : clk_int;  // behavioural source mux

    refclk_monitor #(.CNT_W(CNT_W), .GATE_CYCLES(GATE), .BAD_LIMIT(LIMIT), .SYNC_STAGES(2)) u0 (
        .clk_ref(clk_ref), .rst_n(rst_n), .clk_ext(clk_ext), .clk_ts(clk_ts),
        .clk_int(clk_int), .ctl_pulse(ctl_pulse), .pll_locked(pll_locked),
        .pll_active_ext(pll_active_ext), .ext_select(ext_select),
        .ext_ref_count(ext_ref_count), .ext_tgt_count(ext_tgt_count),
        .ts_ref_count(ts_ref_count), .ts_tgt_count(ts_tgt_count),
        .status_word(status_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input logic [31:0] act, input int lo, input int hi);
        n_chk++;
        if ($isunknown(act) || int'(act) < lo || int'(act) > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk_ref);
        #1;
    endtask

    task automatic strobe(input logic [4:3] v);
        @(posedge clk_ref); #1 ctl_pulse = v;
        @(posedge clk_ref); #1 ctl_pulse = 2'b00;
    endtask

    // cycle-by-cycle model of switch, lock and active-source bits (R3, R4)
    always @(negedge clk_ref) begin
        if (!rst_n) begin
            exp_sel = 1'b0;
            exp_hi  = 3'b000;
        end else begin
            chk("R3 switch", {31'd0, ext_select}, {31'd0, exp_sel});
            chk("R4/R3 status high bits", {29'd0, status_word[31:30], status_word[27]},
                {29'd0, exp_hi});
            exp_hi = {pll_locked, pll_active_ext, exp_sel};
            if (ctl_pulse[3])      exp_sel = 1'b0;
            else if (ctl_pulse[4]) exp_sel = 1'b1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk_ref);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cycles(5);
        // R8: reset state
        chk("R8 status", status_word, 32'h0);
        chk("R8 ext count", ext_tgt_count, 32'h0);
        chk("R8 ts ref count", ts_ref_count, 32'h0);
        chk("R8 switch", {31'd0, ext_select}, 32'h0);
        rst_n = 1'b1;

        // internal source running, external absent
        cycles(700);
        chk("R9 internal, ext missing", status_word, 32'hA000_0000);
        chk("R5 ext bad bit", {31'd0, status_word[29]}, 32'd1);
        chk("R7 absent ext count", ext_tgt_count, 32'h0);
        chk("R1 ext ref count", ext_ref_count, GATE);
        chk("R1 ts ref count", ts_ref_count, GATE);
        chk_rng("R1 ts count 10MHz", ts_tgt_count, 19, 21);
        chk("R2 low bits zero", {5'd0, status_word[26:0]}, 32'h0);

        // external clock present
        ext_on = 1'b1;
        cycles(700);
        chk("R9 internal normal", status_word, 32'h8000_0000);
        chk_rng("R1 ext count 25MHz", ext_tgt_count, 49, 51);

        // set switch and external active
        strobe(2'b10);
        pll_active_ext = 1'b1;
        cycles(700);
        chk("R2/R3 external with switch", status_word, 32'hC800_0000);
        chk_rng("R1 ts count follows mux", ts_tgt_count, 49, 51);

        // both strobes: clear wins
        strobe(2'b11);
        cycles(3);
        chk("R3 clear wins", {31'd0, ext_select}, 32'h0);
        chk("R9 external normal", status_word, 32'hC000_0000);

        strobe(2'b10);
        cycles(3);
        chk("R3 set", {31'd0, ext_select}, 32'd1);
        strobe(2'b01);
        cycles(3);
        chk("R3 clear", {31'd0, ext_select}, 32'h0);

        // external selected but lost
        ext_on = 1'b0;
        pll_locked = 1'b0;
        cycles(500);
        chk("R9 external invalid", status_word, 32'h6000_0000);
        chk("R7 stopped ext count", ext_tgt_count, 32'h0);

        // recovery of external
        ext_on = 1'b1;
        cycles(100);
        chk("R5 ext recovered", status_word, 32'h4000_0000);

        // internal oscillator lost and recovered
        int_on = 1'b0;
        cycles(300);
        chk("R6 int bad", status_word, 32'h5000_0000);
        int_on = 1'b1;
        cycles(100);
        chk("R6 int recovered", status_word, 32'h4000_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule